// File: doc/BRIEF.md
# Circular Load Queue with Squash

This block keeps the loads of an out-of-order core in program order inside a ring buffer. Dispatch appends a load at the tail. Each load is tagged with the slot it lands in and with the store-queue position current at that moment. Retirement frees loads from the head. Squash recovery trims loads from the tail. Each load is carried only as a sequence number, an address and a ready bit. Address generation, cache access and data return belong to other blocks.

The ring has one slot more than the configured capacity. This spare slot lets equal head and tail pointers mean "empty" without any ambiguity. Commit and squash are both driven by comparing sequence numbers, and either one can remove several entries in a single cycle. The block also holds two pieces of recovery state. The first is a blocked load: its flag, a handled flag and its sequence number. The second is a load stalled behind a store: its flag, the store's sequence number and the load's slot. A squash that reaches either of them clears it.

Top module: `load_ring`

## Requirements
- R1: After reset the queue is empty: count 0, head and tail indices 0, full low, empty high, and the blocked and stall records cleared to zero.
- R2: The ring has DEPTH+1 slots. `full` (and `stall_o`) is high exactly when (tail+1) mod (DEPTH+1) equals head, which is when count equals DEPTH. `empty` is high exactly when head equals tail.
- R3: While `ins_valid` is high, `ins_lq_idx` shows the current tail index. `ins_sq_tag` shows {1'b0, sq_tail} when `sq_nonempty` is high and all ones otherwise. An accepted load stores its sequence number, address, ready bit and that tag, and the tail then advances, wrapping from DEPTH back to 0.
- R4: A commit removes, in one cycle, every consecutive head entry whose sequence number is less than or equal to `cmt_seq`. It stops at the first entry that is younger than `cmt_seq`. The head advances with wrap.
- R5: A squash walks backward from the slot just before the tail. It removes every consecutive entry whose sequence number is greater than `sqh_seq`, and the tail moves back to the last removed slot. A decrement below 0 wraps to DEPTH.
- R6: When commit and squash arrive in the same cycle, the commit is applied first and the squash acts on what remains. An insert requested in a cycle with a squash is dropped.
- R7: An insert while full changes nothing. A commit while empty changes nothing.
- R8: A squash whose sequence number is below the recorded blocked sequence number, while the blocked flag is set, clears the blocked flag, the handled flag and the blocked sequence number. Otherwise `blk_set` loads the blocked record and `blk_handled_set` sets the handled flag.
- R9: When a squash removes the slot recorded as the stalling load, the stall flag, the stalling store sequence number and the stalling slot are cleared. Otherwise `stall_set` loads the stall record.
- R10: `count` always equals the number of live entries, and the head outputs show the sequence number, address, ready bit and store tag of the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of the inserted load |
| ins_addr | input | ADDR_W | Address of the inserted load |
| ins_ready | input | 1 | Ready bit of the inserted load |
| sq_nonempty | input | 1 | Store queue holds at least one store |
| sq_tail | input | SQI_W | Current store-queue tail |
| ins_lq_idx | output | IDX_W | Slot the inserted load takes |
| ins_sq_tag | output | SQI_W+1 | Store tag recorded for the inserted load (all ones = none) |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Youngest committed sequence number |
| sqh_valid | input | 1 | Squash request |
| sqh_seq | input | SEQ_W | Loads younger than this are removed |
| blk_set | input | 1 | Record a blocked load |
| blk_seq_i | input | SEQ_W | Sequence number of the blocked load |
| blk_handled_set | input | 1 | Mark the blocked load as handled |
| stall_set | input | 1 | Record a load stalled on a store |
| stall_idx_i | input | IDX_W | Slot of the stalled load |
| stall_sseq_i | input | SEQ_W | Sequence number of the store it waits on |
| count | output | IDX_W | Live entries |
| full | output | 1 | No free slot |
| empty | output | 1 | No live entry |
| stall_o | output | 1 | Dispatch must hold (queue full) |
| head_idx | output | IDX_W | Head slot |
| tail_idx | output | IDX_W | Tail slot |
| head_seq | output | SEQ_W | Sequence number of the oldest load |
| head_addr | output | ADDR_W | Address of the oldest load |
| head_ready | output | 1 | Ready bit of the oldest load |
| head_sq_tag | output | SQI_W+1 | Store tag of the oldest load |
| blocked | output | 1 | Blocked-load flag |
| blk_handled | output | 1 | Blocked load handled flag |
| blk_seq | output | SEQ_W | Blocked load sequence number |
| stalled | output | 1 | Stall flag |
| stall_sseq | output | SEQ_W | Stalling store sequence number |
| stall_lidx | output | IDX_W | Stalling load slot |

## Verification
The bench goes after several corner cases. One is pointer wrap at the odd ring size: a design that wraps at a power of two would show a wrong tail index once the tail passes DEPTH. Another is a multi-entry commit that must stop at the first younger load; a design that commits by count or keeps going would drain too much. It also runs a squash that empties the whole queue, a same-cycle commit-plus-squash that must act on the post-commit state, and inserts against a full queue, which a faulty design would let overwrite the head. Finally, it squashes the slot recorded as stalling, and squashes just above and just below the blocked sequence number, where an off-by-one compare would leave a stale record or clear a live one.

// File: rtl/load_ring.sv
module load_ring #(
  parameter int DEPTH  = 6,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int SQI_W  = 3,
  localparam int RING  = DEPTH + 1,
  localparam int IDX_W = $clog2(RING),
  localparam int TAG_W = SQI_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [SEQ_W-1:0]  ins_seq,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              ins_ready,
  input  logic              sq_nonempty,
  input  logic [SQI_W-1:0]  sq_tail,
  output logic [IDX_W-1:0]  ins_lq_idx,
  output logic [TAG_W-1:0]  ins_sq_tag,
  input  logic              cmt_valid,
  input  logic [SEQ_W-1:0]  cmt_seq,
  input  logic              sqh_valid,
  input  logic [SEQ_W-1:0]  sqh_seq,
  input  logic              blk_set,
  input  logic [SEQ_W-1:0]  blk_seq_i,
  input  logic              blk_handled_set,
  input  logic              stall_set,
  input  logic [IDX_W-1:0]  stall_idx_i,
  input  logic [SEQ_W-1:0]  stall_sseq_i,
  output logic [IDX_W-1:0]  count,
  output logic              full,
  output logic              empty,
  output logic              stall_o,
  output logic [IDX_W-1:0]  head_idx,
  output logic [IDX_W-1:0]  tail_idx,
  output logic [SEQ_W-1:0]  head_seq,
  output logic [ADDR_W-1:0] head_addr,
  output logic              head_ready,
  output logic [TAG_W-1:0]  head_sq_tag,
  output logic              blocked,
  output logic              blk_handled,
  output logic [SEQ_W-1:0]  blk_seq,
  output logic              stalled,
  output logic [SEQ_W-1:0]  stall_sseq,
  output logic [IDX_W-1:0]  stall_lidx
);

  function automatic logic [IDX_W-1:0] fwd(input logic [IDX_W-1:0] p, input int k);
    int s;
    s = int'(p) + k;
    if (s >= RING) s = s - RING;
    return IDX_W'(s);
  endfunction

  function automatic logic [IDX_W-1:0] bwd(input logic [IDX_W-1:0] p, input int k);
    int s;
    s = int'(p) - k;
    if (s < 0) s = s + RING;
    return IDX_W'(s);
  endfunction

  logic [SEQ_W-1:0]  e_seq  [RING];
  logic [ADDR_W-1:0] e_addr [RING];
  logic              e_rdy  [RING];
  logic [TAG_W-1:0]  e_tag  [RING];

  logic [IDX_W-1:0] head, tail;
  int               n_cmt, n_sqh, left;
  logic             go_c, go_s, hit_stall, do_ins;

  assign full        = (fwd(tail, 1) == head);
  assign empty       = (head == tail);
  assign stall_o     = full;
  assign head_idx    = head;
  assign tail_idx    = tail;
  assign ins_lq_idx  = tail;
  assign ins_sq_tag  = sq_nonempty ? {1'b0, sq_tail} : {TAG_W{1'b1}};
  assign head_seq    = e_seq[head];
  assign head_addr   = e_addr[head];
  assign head_ready  = e_rdy[head];
  assign head_sq_tag = e_tag[head];
  assign do_ins      = ins_valid && !sqh_valid && !full;

  always_comb begin
    n_cmt = 0;
    go_c  = cmt_valid;
    for (int k = 0; k < DEPTH; k++) begin
      if (go_c && k < int'(count) && e_seq[fwd(head, k)] <= cmt_seq) n_cmt = n_cmt + 1;
      else go_c = 1'b0;
    end
    left      = int'(count) - n_cmt;
    n_sqh     = 0;
    go_s      = sqh_valid;
    hit_stall = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (go_s && k < left && e_seq[bwd(tail, k + 1)] > sqh_seq) begin
        n_sqh = n_sqh + 1;
        if (stalled && bwd(tail, k + 1) == stall_lidx) hit_stall = 1'b1;
      end else go_s = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= fwd(head, n_cmt);
      tail  <= do_ins ? fwd(tail, 1) : bwd(tail, n_sqh);
      count <= IDX_W'(int'(count) - n_cmt - n_sqh + (do_ins ? 1 : 0));
    end
  end

  always_ff @(posedge clk) begin
    if (do_ins) begin
      e_seq[tail]  <= ins_seq;
      e_addr[tail] <= ins_addr;
      e_rdy[tail]  <= ins_ready;
      e_tag[tail]  <= ins_sq_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blocked     <= 1'b0;
      blk_handled <= 1'b0;
      blk_seq     <= '0;
    end else if (sqh_valid && blocked && sqh_seq < blk_seq) begin
      blocked     <= 1'b0;
      blk_handled <= 1'b0;
      blk_seq     <= '0;
    end else begin
      if (blk_set) begin
        blocked <= 1'b1;
        blk_seq <= blk_seq_i;
      end
      if (blk_handled_set) blk_handled <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hit_stall) begin
      stalled    <= 1'b0;
      stall_sseq <= '0;
      stall_lidx <= '0;
    end else if (stall_set) begin
      stalled    <= 1'b1;
      stall_sseq <= stall_sseq_i;
      stall_lidx <= stall_idx_i;
    end
  end

endmodule

// File: rtl/load_ring_chk.sv
module load_ring_chk #(
  parameter int DEPTH = 6,
  parameter int SEQ_W = 16,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic             cmt_valid,
  input logic             sqh_valid,
  input logic [SEQ_W-1:0] sqh_seq,
  input logic [IDX_W-1:0] count,
  input logic             full,
  input logic             empty,
  input logic             blocked,
  input logic [SEQ_W-1:0] blk_seq
);

  a_r2_full_vs_count: assert property (@(posedge clk) disable iff (!rst_n)
    full == (int'(count) == DEPTH));

  a_r2_empty_vs_count: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (count == '0));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  a_r7_full_insert_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    full && ins_valid |=> int'(count) <= DEPTH && count <= $past(count));

  a_r7_empty_commit_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    empty && cmt_valid && !ins_valid |=> count == '0);

  a_r6_squash_drops_insert: assert property (@(posedge clk) disable iff (!rst_n)
    sqh_valid |=> count <= $past(count));

  a_r8_blocked_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    sqh_valid && blocked && sqh_seq < blk_seq |=> !blocked);

endmodule

bind load_ring load_ring_chk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/load_ring_tb.sv
module load_ring_tb;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 6;
  localparam int SEQ_W  = 16;
  localparam int ADDR_W = 32;
  localparam int SQI_W  = 3;
  localparam int RING   = DEPTH + 1;
  localparam int IDX_W  = $clog2(RING);
  localparam int TAG_W  = SQI_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 0, ins_ready = 0, sq_nonempty = 0;
  logic [SEQ_W-1:0] ins_seq = '0, cmt_seq = '0, sqh_seq = '0, blk_seq_i = '0, stall_sseq_i = '0;
  logic [ADDR_W-1:0] ins_addr = '0;
  logic [SQI_W-1:0] sq_tail = '0;
  logic cmt_valid = 0, sqh_valid = 0, blk_set = 0, blk_handled_set = 0, stall_set = 0;
  logic [IDX_W-1:0] stall_idx_i = '0;
  logic [IDX_W-1:0] ins_lq_idx, count, head_idx, tail_idx, stall_lidx;
  logic [TAG_W-1:0] ins_sq_tag, head_sq_tag;
  logic full, empty, stall_o, head_ready, blocked, blk_handled, stalled;
  logic [SEQ_W-1:0] head_seq, blk_seq, stall_sseq;
  logic [ADDR_W-1:0] head_addr;

  always #(PERIOD/2) clk = ~clk;

  load_ring #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .SQI_W(SQI_W)) u_dut (.*);

  int total = 0, bad = 0;
  int q_seq[$], q_addr[$], q_rdy[$], q_tag[$];
  int m_head = 0, m_tail = 0, nseq = 10;
  int m_bl = 0, m_hd = 0, m_bseq = 0, m_st = 0, m_sseq = 0, m_sidx = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_tag(bit ne, int t);
    return ne ? t : (1 << TAG_W) - 1;
  endfunction

  task automatic compare_state();
    chk("R10", "count", count, q_seq.size());
    chk("R2", "full", full, q_seq.size() == DEPTH);
    chk("R2", "stall_o", stall_o, q_seq.size() == DEPTH);
    chk("R2", "empty", empty, q_seq.size() == 0);
    chk("R4", "head_idx", head_idx, m_head);
    chk("R5", "tail_idx", tail_idx, m_tail);
    if (q_seq.size() > 0) begin
      chk("R10", "head_seq", head_seq, q_seq[0]);
      chk("R10", "head_addr", head_addr, q_addr[0]);
      chk("R10", "head_ready", head_ready, q_rdy[0]);
      chk("R3", "head_sq_tag", head_sq_tag, q_tag[0]);
    end
    chk("R8", "blocked", blocked, m_bl);
    chk("R8", "blk_handled", blk_handled, m_hd);
    chk("R8", "blk_seq", blk_seq, m_bseq);
    chk("R9", "stalled", stalled, m_st);
    chk("R9", "stall_sseq", stall_sseq, m_sseq);
    chk("R9", "stall_lidx", stall_lidx, m_sidx);
  endtask

  task automatic step(bit iv, int addr, bit rdy, bit sqne, int sqt,
                      bit cv, int cseq, bit sv, int sseq,
                      bit bs, int bseq, bit hs, bit ss, int sidx, int sss);
    int pre;
    bit hit;
    ins_valid = iv; ins_seq = SEQ_W'(nseq); ins_addr = ADDR_W'(addr); ins_ready = rdy;
    sq_nonempty = sqne; sq_tail = SQI_W'(sqt);
    cmt_valid = cv; cmt_seq = SEQ_W'(cseq); sqh_valid = sv; sqh_seq = SEQ_W'(sseq);
    blk_set = bs; blk_seq_i = SEQ_W'(bseq); blk_handled_set = hs;
    stall_set = ss; stall_idx_i = IDX_W'(sidx); stall_sseq_i = SEQ_W'(sss);
    #1;
    if (iv) begin
      chk("R3", "ins_lq_idx", ins_lq_idx, m_tail);
      chk("R3", "ins_sq_tag", ins_sq_tag, exp_tag(sqne, sqt));
    end
    pre = q_seq.size();
    hit = 0;
    if (cv)
      while (q_seq.size() > 0 && q_seq[0] <= cseq) begin
        void'(q_seq.pop_front()); void'(q_addr.pop_front());
        void'(q_rdy.pop_front()); void'(q_tag.pop_front());
        m_head = (m_head + 1) % RING;
      end
    if (sv)
      while (q_seq.size() > 0 && q_seq[$] > sseq) begin
        int idx = (m_tail + RING - 1) % RING;
        if (m_st != 0 && idx == m_sidx) hit = 1;
        void'(q_seq.pop_back()); void'(q_addr.pop_back());
        void'(q_rdy.pop_back()); void'(q_tag.pop_back());
        m_tail = idx;
      end
    if (iv && !sv && pre < DEPTH) begin
      q_seq.push_back(nseq); q_addr.push_back(addr);
      q_rdy.push_back(rdy); q_tag.push_back(exp_tag(sqne, sqt));
      m_tail = (m_tail + 1) % RING;
    end
    if (sv && m_bl != 0 && sseq < m_bseq) begin
      m_bl = 0; m_hd = 0; m_bseq = 0;
    end else begin
      if (bs) begin m_bl = 1; m_bseq = bseq; end
      if (hs) m_hd = 1;
    end
    if (hit) begin m_st = 0; m_sseq = 0; m_sidx = 0; end
    else if (ss) begin m_st = 1; m_sseq = sss; m_sidx = sidx; end
    if (iv) nseq++;
    @(posedge clk);
    @(negedge clk);
    compare_state();
  endtask

  task automatic ins1();
    step(1, nseq * 3, 1, 1, nseq % 8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4177));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_state();
    // R1 reset state
    chk("R1", "reset count", count, 0);
    chk("R1", "reset empty", empty, 1);

    // R7 commit on empty is ignored
    step(0, 0, 0, 0, 0, 1, 60000, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 tag with empty store queue
    step(1, 5, 0, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2 fill to full, R7 insert while full
    repeat (DEPTH) ins1();
    chk("R7", "full before extra insert", full, 1);
    ins1();
    // R4 commit stops at the first younger load
    step(0, 0, 0, 0, 0, 1, q_seq[2], 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 R5 wrap past the last slot
    repeat (3) ins1();
    // R9 stall on the youngest, then R8 block, then squash beyond both
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, q_seq[1], 0, 1, (m_tail + RING - 1) % RING, 77);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    // R8 squash equal to blocked seq does not clear
    step(0, 0, 0, 0, 0, 0, 0, 1, m_bseq, 0, 0, 0, 0, 0, 0);
    // R6 commit and squash together, insert dropped
    step(1, 9, 1, 1, 2, 1, q_seq[0], 1, q_seq[0], 0, 0, 0, 0, 0, 0);
    // R5 squash everything
    repeat (4) ins1();
    step(0, 0, 0, 0, 0, 0, 0, 1, q_seq[0] - 1, 0, 0, 0, 0, 0, 0);
    chk("R5", "squash all leaves empty", empty, 1);
    idle();

    for (int n = 0; n < 4000; n++) begin
      int sz = q_seq.size();
      bit iv = ($urandom % 100) < 55;
      bit cv = ($urandom % 100) < 25;
      bit sv = ($urandom % 100) < 8;
      int cseq = sz > 0 ? q_seq[$urandom % sz] : int'($urandom % 50);
      int sseq = sz > 0 ? q_seq[$urandom % sz] - int'($urandom % 2) : nseq;
      bit bs = ($urandom % 100) < 6;
      bit hs = ($urandom % 100) < 5;
      bit ss = sz > 0 && ($urandom % 100) < 6;
      int sidx = sz > 0 ? (m_head + int'($urandom % sz)) % RING : 0;
      step(iv, int'($urandom), $urandom % 2, $urandom % 2, $urandom % 8,
           cv, cseq, sv, sseq, bs, nseq - int'($urandom % 8), hs,
           ss, sidx, int'($urandom % 1000));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule